// File: doc/BRIEF.md
# Decoded RAM/ROM Memory Subsystem

This block is a 16-bit memory system on a 16-bit word address bus. It is made of byte-wide storage banks that each hold 8K locations. The banks are paired side by side to form 16-bit words, and the pairs are stacked to add depth. A 3-to-8 decoder looks at the top three address bits and drives active-low selects for each bank pair. These selects place 16K words of RAM and 8K words of ROM at fixed, non-adjacent ranges of the map. Every other range is left empty.

A requester presents one access per cycle using a valid strobe, a write flag, an address and write data. A RAM write takes effect on the rising clock edge. Read data is registered, so it appears in the cycle after the request. The ROM holds a fixed function of the address, so it needs no load step. A write aimed at the ROM has no effect and produces a one-cycle fault pulse. A read from an empty range returns zero and sets a flag.

To keep elaboration small, each bank only populates the low `STORE_AW` bits of its 13-bit in-bank address. Word addresses inside a RAM pair that differ only in the bits above that share one location.

Top module: `memsys_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `rd_data` is 0000h and `rd_unmapped` and `wr_fault` are 0.
- R2: Address bits 15:13 select the region. Value 1 (2000h–3FFFh) and value 2 (4000h–5FFFh) are RAM. Value 4 (8000h–9FFFh) is ROM. Values 0, 3, 5, 6 and 7 are unmapped.
- R3: At most one bank pair is selected in any cycle, and none is selected when `req_valid` is low.
- R4: A request with `req_valid`=1 and `req_write`=1 to RAM stores `req_wdata` on the rising edge. A read request (`req_valid`=1, `req_write`=0) shows the stored word on `rd_data` in the following cycle. Bits 15:8 and 7:0 come from the two banks of the pair.
- R5: A ROM read returns the requested address XOR A5A5h, one cycle after the request.
- R6: A write to ROM leaves the ROM contents unchanged. It raises `wr_fault` for exactly the one cycle after the request; otherwise `wr_fault` is 0.
- R7: A read from an unmapped address returns 0000h on `rd_data` and raises `rd_unmapped` for that one result cycle; otherwise `rd_unmapped` is 0.
- R8: A write to an unmapped address changes no RAM location and raises neither flag.
- R9: `rd_data` keeps its last value in every cycle that follows a cycle with no read request.
- R10: Inside a RAM pair, only in-bank address bits `STORE_AW-1`:0 (default 9) pick a location. Two addresses in the same pair that differ only in bits 12:`STORE_AW` reach the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| rd_unmapped | output | 1 | Previous read hit an empty range |
| wr_fault | output | 1 | Previous write targeted ROM |

## Verification
The assertions check the following on every cycle:
- at most one pair is selected, and none is selected while idle;
- the ROM value appears one cycle after a ROM read;
- the fault pulse and the unmapped flag follow their requests exactly;
- read data holds between reads.

Only the bench scenarios can show that RAM words survive other accesses, that both bytes of a word land in the correct lanes, that writes to unmapped space and to ROM leave storage untouched, and that addresses alias inside a pair.

// File: rtl/memsys_pkg.sv
package memsys_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int LANES   = DATA_W / BYTE_W;
    localparam int BANK_AW = 13;
    localparam int SEL_W   = ADDR_W - BANK_AW;
    localparam int NUM_SEL = 1 << SEL_W;

    localparam logic [SEL_W-1:0] SEL_RAM_LO = 3'd1;
    localparam logic [SEL_W-1:0] SEL_RAM_HI = 3'd2;
    localparam logic [SEL_W-1:0] SEL_ROM    = 3'd4;
    localparam logic [DATA_W-1:0] ROM_MASK  = 16'hA5A5;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              unmapped;
        logic              fault;
    } mem_out_t;
endpackage

// File: rtl/memsys_dec3to8.sv
module memsys_dec3to8 #(
    parameter int SW = 3,
    localparam int NO = 1 << SW
) (
    input  logic [SW-1:0] sel,
    input  logic          en_hi,
    input  logic          en_a_n,
    input  logic          en_b_n,
    output logic [NO-1:0] y_n
);
    logic active;
    assign active = en_hi & ~(en_a_n | en_b_n);

    for (genvar i = 0; i < NO; i++) begin : g_out
        assign y_n[i] = ~(active && (sel == SW'(i)));
    end
endmodule

// File: rtl/memsys_ram_bank.sv
module memsys_ram_bank #(
    parameter int AW       = 13,
    parameter int STORE_AW = 9,
    parameter int W        = 8,
    localparam int DEPTH   = 1 << STORE_AW
) (
    input  logic          clk,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cells [DEPTH];
    logic [STORE_AW-1:0] idx;
    assign idx = addr[STORE_AW-1:0];

    if (STORE_AW < AW) begin : g_alias
        logic unused_hi;
        assign unused_hi = ^addr[AW-1:STORE_AW];
    end

    always_ff @(posedge clk) begin
        if (!cs_n && !we_n) begin
            cells[idx] <= wdata;
        end
    end

    assign rdata = (!cs_n && !oe_n) ? cells[idx] : '0;
endmodule

// File: rtl/memsys_rom_bank.sv
module memsys_rom_bank #(
    parameter int AW = 13,
    parameter int SW = 3,
    parameter logic [SW-1:0] REGION = 3'd4,
    parameter int LANE = 0,
    parameter logic [15:0] MASK = 16'hA5A5
) (
    input  logic          cs_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    output logic [7:0]    rdata
);
    logic [15:0] word;
    assign word  = {REGION, addr} ^ MASK;
    assign rdata = (!cs_n && !oe_n) ? word[LANE*8 +: 8] : '0;
endmodule

// File: rtl/memsys_top.sv
module memsys_top
    import memsys_pkg::*;
#(
    parameter int STORE_AW = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    output logic [15:0] rd_data,
    output logic        rd_unmapped,
    output logic        wr_fault
);
    localparam int NPAIR = 3;

    logic [NUM_SEL-1:0] dec_n;
    logic [NPAIR-1:0]   pair_cs_n;
    logic               we_n;
    logic               oe_n;
    logic [DATA_W-1:0]  pair_data [NPAIR];
    logic [DATA_W-1:0]  bus_data;
    logic [BANK_AW-1:0] bank_addr;

    mem_out_t st_d;
    mem_out_t st_q;

    memsys_dec3to8 #(.SW(SEL_W)) u_dec (
        .sel    (req_addr[ADDR_W-1:BANK_AW]),
        .en_hi  (req_valid),
        .en_a_n (1'b0),
        .en_b_n (~rst_n),
        .y_n    (dec_n)
    );

    assign pair_cs_n[0] = dec_n[SEL_RAM_LO];
    assign pair_cs_n[1] = dec_n[SEL_RAM_HI];
    assign pair_cs_n[2] = dec_n[SEL_ROM];

    logic unused_dec;
    assign unused_dec = ^{dec_n[0], dec_n[3], dec_n[5], dec_n[6], dec_n[7]};

    assign we_n      = ~req_write;
    assign oe_n      = req_write;
    assign bank_addr = req_addr[BANK_AW-1:0];

    for (genvar p = 0; p < 2; p++) begin : g_ram_pair
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            memsys_ram_bank #(
                .AW(BANK_AW), .STORE_AW(STORE_AW), .W(BYTE_W)
            ) u_bank (
                .clk   (clk),
                .cs_n  (pair_cs_n[p]),
                .we_n  (we_n),
                .oe_n  (oe_n),
                .addr  (bank_addr),
                .wdata (req_wdata[l*BYTE_W +: BYTE_W]),
                .rdata (pair_data[p][l*BYTE_W +: BYTE_W])
            );
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_rom_lane
        memsys_rom_bank #(
            .AW(BANK_AW), .SW(SEL_W), .REGION(SEL_ROM), .LANE(l), .MASK(ROM_MASK)
        ) u_rom (
            .cs_n  (pair_cs_n[2]),
            .oe_n  (oe_n),
            .addr  (bank_addr),
            .rdata (pair_data[2][l*BYTE_W +: BYTE_W])
        );
    end

    always_comb begin
        bus_data = '0;
        for (int p = 0; p < NPAIR; p++) begin
            bus_data = bus_data | pair_data[p];
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.unmapped = 1'b0;
        st_d.fault    = 1'b0;
        if (req_valid && !req_write) begin
            st_d.rdata    = bus_data;
            st_d.unmapped = &pair_cs_n;
        end
        if (req_valid && req_write && !pair_cs_n[2]) begin
            st_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data     = st_q.rdata;
    assign rd_unmapped = st_q.unmapped;
    assign wr_fault    = st_q.fault;
endmodule

// File: rtl/memsys_checker.sv
module memsys_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [15:0] req_addr,
    input logic [15:0] rd_data,
    input logic        rd_unmapped,
    input logic        wr_fault,
    input logic [2:0]  pair_cs_n
);
    logic rom_hit;
    logic ram_hit;
    logic rd_req;
    assign rom_hit = req_addr[15:13] == 3'd4;
    assign ram_hit = (req_addr[15:13] == 3'd1) || (req_addr[15:13] == 3'd2);
    assign rd_req  = req_valid && !req_write;

    a_r3_single_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~pair_cs_n) <= 1);

    a_r3_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (pair_cs_n == 3'b111));

    a_r5_rom_value: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rom_hit) |=> (rd_data == ($past(req_addr) ^ 16'hA5A5)));

    a_r6_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && rom_hit) |=> wr_fault);

    a_r6_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && rom_hit) |=> !wr_fault);

    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rom_hit && !ram_hit) |=> (rd_unmapped && rd_data == 16'h0000));

    a_r7_mapped_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && !rom_hit && !ram_hit) |=> !rd_unmapped);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data));
endmodule

bind memsys_top memsys_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .rd_data     (rd_data),
    .rd_unmapped (rd_unmapped),
    .wr_fault    (wr_fault),
    .pair_cs_n   (pair_cs_n)
);

// File: tb/memsys_top_tb_top.sv
module memsys_top_tb_top;
    localparam int STORE_AW = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rd_data;
    logic        rd_unmapped;
    logic        wr_fault;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] ref_ram [int];
    logic [15:0] exp_rd = '0;

    memsys_top #(.STORE_AW(STORE_AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .rd_unmapped(rd_unmapped), .wr_fault(wr_fault)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int key_of(input logic [15:0] a);
        return int'(a[15:13]) * 65536 + int'(a[STORE_AW-1:0]);
    endfunction

    // One request per clock; called at a falling edge, returns at the next.
    task automatic op(input string tag, input bit v, input bit w,
                      input logic [15:0] a, input logic [15:0] d);
        bit is_rom, is_ram;
        logic exp_unm, exp_flt;
        is_rom = (a[15:13] == 3'd4);
        is_ram = (a[15:13] == 3'd1) || (a[15:13] == 3'd2);
        exp_unm = v && !w && !is_rom && !is_ram;
        exp_flt = v && w && is_rom;
        if (v && !w) begin
            if (is_ram) exp_rd = ref_ram.exists(key_of(a)) ? ref_ram[key_of(a)] : 16'hxxxx;
            else if (is_rom) exp_rd = a ^ 16'hA5A5;
            else exp_rd = 16'h0000;
        end
        if (v && w && is_ram) ref_ram[key_of(a)] = d;
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        chk(tag, "rd_data", rd_data, exp_rd);
        chk(tag, "rd_unmapped", {15'd0, rd_unmapped}, {15'd0, exp_unm});
        chk(tag, "wr_fault", {15'd0, wr_fault}, {15'd0, exp_flt});
    endtask

    task automatic idle(input string tag);
        op(tag, 1'b0, 1'b0, 16'h0000, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "rd_data", rd_data, 16'h0000);
        chk("R1", "rd_unmapped", {15'd0, rd_unmapped}, 16'h0000);
        chk("R1", "wr_fault", {15'd0, wr_fault}, 16'h0000);
        rst_n = 1'b1;
        idle("R1");

        // R4/R2: RAM writes at region boundaries, both pairs
        op("R4", 1, 1, 16'h2000, 16'h1234);
        op("R4", 1, 1, 16'h3FFF, 16'hABCD);
        op("R4", 1, 1, 16'h4000, 16'h00FF);
        op("R4", 1, 1, 16'h5FFF, 16'hFF00);
        op("R4", 1, 1, 16'h2005, 16'h5A5A);
        op("R2", 1, 0, 16'h2000, 16'h0);
        op("R2", 1, 0, 16'h3FFF, 16'h0);
        op("R2", 1, 0, 16'h4000, 16'h0);
        op("R2", 1, 0, 16'h5FFF, 16'h0);
        op("R4", 1, 0, 16'h2005, 16'h0);
        // R4: back-to-back write then read of the same word
        op("R4", 1, 1, 16'h4123, 16'hC3E1);
        op("R4", 1, 0, 16'h4123, 16'h0);
        for (int i = 0; i < 16; i++) op("R4", 1, 1, 16'h2100 + 16'(i), 16'(i * 16'h1111 + 7));
        for (int i = 15; i >= 0; i--) op("R4", 1, 0, 16'h2100 + 16'(i), 16'h0);

        // R5: ROM reads
        op("R5", 1, 0, 16'h8000, 16'h0);
        op("R5", 1, 0, 16'h9FFF, 16'h0);
        op("R5", 1, 0, 16'h8A5A, 16'h0);
        op("R5", 1, 0, 16'h9234, 16'h0);

        // R6: ROM write ignored, fault pulse for one cycle
        op("R6", 1, 1, 16'h8010, 16'hDEAD);
        idle("R6");
        op("R6", 1, 0, 16'h8010, 16'h0);
        op("R6", 1, 1, 16'h9FFF, 16'hBEEF);
        op("R6", 1, 1, 16'h8000, 16'h1111);
        op("R6", 1, 0, 16'h9FFF, 16'h0);

        // R7/R2: unmapped reads, including edges next to mapped regions
        op("R7", 1, 0, 16'h0000, 16'h0);
        op("R7", 1, 0, 16'h1FFF, 16'h0);
        op("R4", 1, 0, 16'h2000, 16'h0);
        op("R7", 1, 0, 16'h6000, 16'h0);
        op("R7", 1, 0, 16'h7FFF, 16'h0);
        op("R7", 1, 0, 16'hA000, 16'h0);
        op("R7", 1, 0, 16'hE123, 16'h0);

        // R8: unmapped writes change no RAM and raise no flag
        op("R8", 1, 1, 16'h0000, 16'h7777);
        op("R8", 1, 1, 16'h6000, 16'h7777);
        op("R8", 1, 1, 16'hC005, 16'h7777);
        op("R8", 1, 0, 16'h2000, 16'h0);
        op("R8", 1, 0, 16'h4000, 16'h0);
        op("R8", 1, 0, 16'h2005, 16'h0);

        // R9: data holds across idle cycles and writes
        op("R9", 1, 0, 16'h3FFF, 16'h0);
        idle("R9");
        idle("R9");
        op("R9", 1, 1, 16'h2222, 16'h9999);
        op("R9", 0, 1, 16'h2000, 16'hFFFF);
        op("R9", 1, 0, 16'h2000, 16'h0);

        // R10: aliasing above the populated in-bank bits
        op("R10", 1, 1, 16'h2000 + 16'(1 << STORE_AW), 16'h4242);
        op("R10", 1, 0, 16'h2000, 16'h0);
        op("R10", 1, 1, 16'h5FFF, 16'h6161);
        op("R10", 1, 0, 16'h5FFF & ~16'(1 << STORE_AW), 16'h0);

        // R3: idle request leaves every pair deselected (ROM write while invalid: no fault)
        op("R3", 0, 1, 16'h8000, 16'h0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule